// File: doc/BRIEF.md
# Clock output channel control

This block governs eight clock output channels. Each channel ends in a pin pair, a true pin and a complement pin. A stand-in divider produces the channel clock from the core clock. The divider is a counter that toggles a phase flop. The block then decides whether the pair is driven, what the complement pin carries, and when the divider must be held. A channel drives its pins only when software has enabled it and its external output-enable line is also high. Otherwise both pins of the pair are released to high impedance. The pair can run as a differential pair, where the complement pin is the inverse of the true pin. It can also run as two single-ended copies, either in phase or inverted.

Each channel belongs to one of two PLL domains. A per-channel select picks the domain. A domain enters a resynchronisation window in two cases: when its loss-of-lock indication drops, and when its manual resync bit is released. The window length is derived from the clock period and a 350 ns worst-case settling time. During the window every divider in that domain is held in reset and its true pin stays low. When the window closes, all of those dividers leave reset on the same edge, so channels with the same ratio come out phase aligned. A channel can also be powered down. This holds its divider in reset and releases its pins.

Top module: `clkout_ctrl`

## Requirements
- R1: Channel i drives its pins (q_oe[i]=1) exactly when drv_en_reg[i] and oe_pin[i] are both 1 and pwr_dn[i] is 0. Each channel is decided on its own.
- R2: A channel that is not driving has q_oe[i]=0, which releases both pins of the pair to high impedance.
- R3: With its divider running, q_p[i] is a clock that holds each level for div_half[i]+1 core cycles. The field for channel i is div_half[4i+3:4i].
- R4: In single-ended mode (se_mode[i]=1) with se_inv[i]=0, q_n[i] equals q_p[i].
- R5: In single-ended mode with se_inv[i]=1, q_n[i] is the inverse of q_p[i]. In differential mode (se_mode[i]=0), q_n[i] is the inverse of q_p[i] whatever se_inv[i] holds.
- R6: After reset, q_p is all zero and resync_busy is all zero.
- R7: While pwr_dn[i]=1, q_oe[i]=0 and q_p[i]=0. Once pwr_dn[i] is released, q_p[i] first rises on the (div_half[i]+1)-th clock edge.
- R8: A 1-to-0 change of pll_lol[k] sets resync_busy[k] on the next edge. The flag then stays set for RESYNC_CYC cycles (35 by default). A 0-to-1 change of pll_lol[k] starts no window.
- R9: resync_busy[k] is set while resync_req[k] is 1. After release it stays set for RESYNC_CYC-1 more cycles, counting samples taken after the first edge that sees the bit low.
- R10: While resync_busy[k] is set, q_p is 0 on every channel in domain k, and channels in the other domain keep toggling. When the window ends, the channels of domain k that share a ratio toggle in phase.
- R11: Channel i belongs to domain pll_sel[i] (0 or 1). Changing the select moves the channel to the other domain's resync window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| drv_en_reg | input | 8 | Software enable per channel |
| oe_pin | input | 8 | External output-enable line per channel |
| pwr_dn | input | 8 | Per-channel power-down |
| se_mode | input | 8 | 1: single-ended pair, 0: differential pair |
| se_inv | input | 8 | In single-ended mode, 1 inverts the complement pin |
| div_half | input | 32 | Per-channel half-period minus one, 4 bits each |
| pll_sel | input | 8 | Domain select per channel |
| pll_lol | input | 2 | Loss-of-lock per PLL domain |
| resync_req | input | 2 | Manual resync bit per PLL domain |
| q_p | output | 8 | True pin data |
| q_n | output | 8 | Complement pin data |
| q_oe | output | 8 | Drive enable for both pins of the pair |
| resync_busy | output | 2 | Resync window active per domain |

## Verification
A window counter stuck at a wrong value shows up within one cycle of the triggering edge. The busy flag either fails to rise or lasts the wrong number of cycles, and the true pins of that domain either glitch high inside the window or stay frozen after it. A divider whose reset is released on the wrong cycle leaves its channel out of phase with its domain peers. This is visible on the pins within one half-period after the window closes. A wrong enable, mode or domain decode is combinational and visible in the same cycle.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

  typedef enum logic [1:0] {
    PAIR_DIFF = 2'd0,
    PAIR_SAME = 2'd1,
    PAIR_INV  = 2'd2
  } pair_mode_e;

  function automatic int unsigned window_cycles(input int unsigned win_ps,
                                                input int unsigned per_ps);
    return (win_ps + per_ps - 1) / per_ps;
  endfunction

endpackage

// File: rtl/resync_timer.sv
module resync_timer #(
  parameter int unsigned LOAD = 35
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lol_i,
  input  logic hold_req_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(LOAD + 1);

  logic             lol_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lol_fall;

  always_comb begin
    lol_fall = lol_q & ~lol_i;
    cnt_d    = cnt_q;
    if (hold_req_i || lol_fall) begin
      cnt_d = CNT_W'(LOAD);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lol_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      lol_q <= lol_i;
      cnt_q <= cnt_d;
    end
  end

  assign busy_o = (cnt_q != '0);

  // R8
  lol_window_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lol_q && !lol_i) |=> busy_o);

  // R9
  req_release_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_req_i) |-> busy_o);

  // R8
  window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(LOAD));

endmodule

// File: rtl/out_divider.sv
module out_divider #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             clk_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             ph_q, ph_d;

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    if (hold_i) begin
      cnt_d = '0;
      ph_d  = 1'b0;
    end else if (cnt_q >= half_i) begin
      cnt_d = '0;
      ph_d  = ~ph_q;
    end else begin
      cnt_d = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign clk_o = ph_q;

  // R7
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> !clk_o);

  // R3
  div_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && cnt_q < half_i) |=> $stable(clk_o));

endmodule

// File: rtl/pin_stage.sv
module pin_stage
  import clkout_pkg::*;
(
  input  logic ph_i,
  input  logic en_i,
  input  logic se_mode_i,
  input  logic se_inv_i,
  output logic p_o,
  output logic n_o,
  output logic oe_o
);
  pair_mode_e mode;

  always_comb begin
    if (!se_mode_i)    mode = PAIR_DIFF;
    else if (se_inv_i) mode = PAIR_INV;
    else               mode = PAIR_SAME;
  end

  always_comb begin
    p_o  = ph_i;
    oe_o = en_i;
    unique case (mode)
      PAIR_SAME: n_o = ph_i;
      default:   n_o = ~ph_i;
    endcase
  end

endmodule

// File: rtl/clkout_ctrl.sv
module clkout_ctrl
  import clkout_pkg::*;
#(
  parameter int unsigned NUM_OUT       = 8,
  parameter int unsigned NUM_PLL       = 2,
  parameter int unsigned DIV_W         = 4,
  parameter int unsigned CLK_PERIOD_PS = 10000,
  parameter int unsigned RESYNC_WIN_PS = 350000,
  localparam int unsigned PSEL_W       = (NUM_PLL > 1) ? $clog2(NUM_PLL) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_OUT-1:0]         drv_en_reg,
  input  logic [NUM_OUT-1:0]         oe_pin,
  input  logic [NUM_OUT-1:0]         pwr_dn,
  input  logic [NUM_OUT-1:0]         se_mode,
  input  logic [NUM_OUT-1:0]         se_inv,
  input  logic [NUM_OUT*DIV_W-1:0]   div_half,
  input  logic [NUM_OUT*PSEL_W-1:0]  pll_sel,
  input  logic [NUM_PLL-1:0]         pll_lol,
  input  logic [NUM_PLL-1:0]         resync_req,
  output logic [NUM_OUT-1:0]         q_p,
  output logic [NUM_OUT-1:0]         q_n,
  output logic [NUM_OUT-1:0]         q_oe,
  output logic [NUM_PLL-1:0]         resync_busy
);
  localparam int unsigned RESYNC_CYC = window_cycles(RESYNC_WIN_PS, CLK_PERIOD_PS);

  logic rst_meta, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  for (genvar k = 0; k < NUM_PLL; k++) begin : g_pll
    resync_timer #(.LOAD(RESYNC_CYC)) u_timer (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .lol_i      (pll_lol[k]),
      .hold_req_i (resync_req[k]),
      .busy_o     (resync_busy[k])
    );
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    logic [PSEL_W-1:0] sel;
    logic              hold, ph, en;

    assign sel  = pll_sel[i*PSEL_W +: PSEL_W];
    assign hold = pwr_dn[i] | resync_busy[sel];
    assign en   = drv_en_reg[i] & oe_pin[i] & ~pwr_dn[i];

    out_divider #(.DIV_W(DIV_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .hold_i (hold),
      .half_i (div_half[i*DIV_W +: DIV_W]),
      .clk_o  (ph)
    );

    pin_stage u_pin (
      .ph_i      (ph & ~hold),
      .en_i      (en),
      .se_mode_i (se_mode[i]),
      .se_inv_i  (se_inv[i]),
      .p_o       (q_p[i]),
      .n_o       (q_n[i]),
      .oe_o      (q_oe[i])
    );

    // R10
    domain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      resync_busy[sel] |-> !q_p[i]);

    // R7
    pwr_dn_release_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      pwr_dn[i] |-> (!q_oe[i] && !q_p[i]));
  end

endmodule

// File: tb/sim_clkout_ctrl.sv
module sim_clkout_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  drv_en_reg, oe_pin, pwr_dn, se_mode, se_inv, pll_sel;
  logic [31:0] div_half;
  logic [1:0]  pll_lol, resync_req;
  logic [7:0]  q_p, q_n, q_oe;
  logic [1:0]  resync_busy;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  localparam int WIN = 35;

  clkout_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .drv_en_reg(drv_en_reg), .oe_pin(oe_pin),
    .pwr_dn(pwr_dn), .se_mode(se_mode), .se_inv(se_inv), .div_half(div_half),
    .pll_sel(pll_sel), .pll_lol(pll_lol), .resync_req(resync_req),
    .q_p(q_p), .q_n(q_n), .q_oe(q_oe), .resync_busy(resync_busy)
  );

  always #5 clk = ~clk;

  // fields: enable reg, pin, power-down, se mode, se invert, expected q_oe
  localparam logic [47:0] VEC [6] = '{
    {8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hFF},
    {8'hF0, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'hF0},
    {8'hFF, 8'h0F, 8'h00, 8'hFF, 8'hFF, 8'h0F},
    {8'hAA, 8'hCC, 8'h00, 8'h0F, 8'h05, 8'h88},
    {8'hFF, 8'hFF, 8'h81, 8'h3C, 8'h30, 8'h7E},
    {8'h00, 8'hFF, 8'h00, 8'h00, 8'hFF, 8'h00}
  };

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic high_len(input int idx, output int len);
    while (q_p[idx] !== 1'b0) step();
    while (q_p[idx] !== 1'b1) step();
    len = 0;
    while (q_p[idx] === 1'b1) begin len++; step(); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int len, cnt;
    bit pair_ok, low_ok, moved, other_ok;
    logic [7:0] p_first, exp_n;

    rst_n = 1'b0;
    drv_en_reg = 8'hFF; oe_pin = 8'hFF; pwr_dn = 8'h00;
    se_mode = 8'h00; se_inv = 8'h00;
    pll_sel = 8'hF0;                 // 0-3 on PLL0, 4-7 on PLL1
    div_half = 32'h2222_2222;
    div_half[23:20] = 4'd5;          // channel 5 ratio 5
    pll_lol = 2'b00; resync_req = 2'b00;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R6 reset state
    check(q_p == 8'h00, "R6 q_p", q_p, 0);
    check(resync_busy == 2'b00, "R6 busy", resync_busy, 0);
    repeat (4) step();

    // table walk: R1 R2 R4 R5
    foreach (VEC[v]) begin
      {drv_en_reg, oe_pin, pwr_dn, se_mode, se_inv} = VEC[v][47:8];
      step(); step();
      check(q_oe == VEC[v][7:0], "R1/R2 q_oe", q_oe, VEC[v][7:0]);
      pair_ok = 1'b1;
      exp_n = '0;
      for (int s = 0; s < 12; s++) begin
        for (int i = 0; i < 8; i++) begin
          exp_n[i] = (se_mode[i] && !se_inv[i]) ? q_p[i] : ~q_p[i];
        end
        if ((q_n & VEC[v][7:0]) !== (exp_n & VEC[v][7:0])) pair_ok = 1'b0;
        step();
      end
      check(pair_ok, "R4/R5 pair relation", q_n, exp_n);
    end
    drv_en_reg = 8'hFF; oe_pin = 8'hFF; pwr_dn = 8'h00; se_mode = 8'h00; se_inv = 8'h00;
    step();

    // R3 level lengths
    high_len(0, len);
    check(len == 3, "R3 ch0 high length", len, 3);
    high_len(5, len);
    check(len == 6, "R3 ch5 high length", len, 6);

    // R7 power-down and restart
    pwr_dn[2] = 1'b1;
    low_ok = 1'b1;
    for (int s = 0; s < 10; s++) begin
      step();
      if (q_p[2] !== 1'b0 || q_oe[2] !== 1'b0) low_ok = 1'b0;
    end
    check(low_ok, "R7 powered down", {q_oe[2], q_p[2]}, 0);
    pwr_dn[2] = 1'b0;
    step();
    cnt = 0;
    while (q_p[2] === 1'b0 && cnt < 20) begin cnt++; step(); end
    check(cnt == 2, "R7 first rise edge", cnt + 1, 3);

    // misalign channel 1, then resync PLL0 via lol fall
    pwr_dn[1] = 1'b1; step(); pwr_dn[1] = 1'b0;
    pll_lol[0] = 1'b1;
    other_ok = 1'b1;
    for (int s = 0; s < 3; s++) begin
      step();
      if (resync_busy[0] !== 1'b0) other_ok = 1'b0;
    end
    check(other_ok, "R8 rising lol no window", resync_busy, 0);
    pll_lol[0] = 1'b0;
    step();
    cnt = 0; low_ok = 1'b1; moved = 1'b0; other_ok = 1'b1;
    p_first = q_p;
    while (resync_busy[0] === 1'b1 && cnt < 100) begin
      cnt++;
      if (q_p[3:0] !== 4'h0) low_ok = 1'b0;
      if (resync_busy[1] !== 1'b0) other_ok = 1'b0;
      if (q_p[7:4] !== p_first[7:4]) moved = 1'b1;
      step();
    end
    check(cnt == WIN, "R8 window length", cnt, WIN);
    check(low_ok, "R10 domain held low", q_p, 0);
    check(moved && other_ok, "R10 other domain runs", {moved, other_ok}, 2'b11);
    pair_ok = 1'b1; moved = 1'b0;
    for (int s = 0; s < 30; s++) begin
      if (q_p[3:0] !== 4'h0 && q_p[3:0] !== 4'hF) pair_ok = 1'b0;
      if (q_p[0]) moved = 1'b1;
      step();
    end
    check(pair_ok && moved, "R10 aligned restart", q_p[3:0], 4'hF);

    // R9 manual resync on PLL1
    resync_req[1] = 1'b1;
    low_ok = 1'b1;
    for (int s = 0; s < 4; s++) begin
      step();
      if (resync_busy[1] !== 1'b1 || q_p[7:4] !== 4'h0) low_ok = 1'b0;
    end
    check(low_ok, "R9 held while requested", {resync_busy, q_p}, 0);
    resync_req[1] = 1'b0;
    step();
    cnt = 0;
    while (resync_busy[1] === 1'b1 && cnt < 100) begin cnt++; step(); end
    check(cnt == WIN - 1, "R9 tail length", cnt, WIN - 1);

    // R11 move channel 4 to PLL0
    pll_sel[4] = 1'b0;
    repeat (4) step();
    pll_lol[0] = 1'b1; step(); pll_lol[0] = 1'b0; step();
    cnt = 0; low_ok = 1'b1; moved = 1'b0;
    p_first = q_p;
    while (resync_busy[0] === 1'b1 && cnt < 100) begin
      cnt++;
      if (q_p[4] !== 1'b0) low_ok = 1'b0;
      if (q_p[5] !== p_first[5]) moved = 1'b1;
      step();
    end
    check(low_ok && cnt == WIN, "R11 ch4 follows PLL0", {low_ok, cnt}, {1'b1, WIN});
    check(moved, "R11 ch5 stays on PLL1", moved, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule